// File: doc/BRIEF.md
# Crosspoint Switch Control Memory

This block stores the open/closed state of every crosspoint in a switch matrix of 12 rows by 8 columns, one control bit per crosspoint, 96 bits in all. A host selects one crosspoint with a 4-bit row code and a 3-bit column code, presents a data bit, and raises a write strobe. While the strobe is high the selected bit follows the data input. When the strobe drops, the bit keeps the value it last took. A separate clear input opens every crosspoint at once. A 1 in a cell means the crosspoint is closed and a 0 means it is open.

The row code space is sparse. Codes 0 to 5 reach rows 0 to 5, codes 8 to 13 reach rows 6 to 11, and codes 6, 7, 14 and 15 reach nothing. All host inputs are brought into the system clock domain through a synchronizer chain of equal depth, so address, data, strobe and clear stay aligned. The level-sensitive write is then carried out by clocked registers, with no latches. The whole memory appears as one parallel 96-bit vector. Bit index = column × 12 + row index, where the row index is the one obtained after the sparse code is mapped.

Top module: `crosspoint_ctrl_mem`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all 96 bits of `xpt_state_o` are 0 after that edge.
- R2: Row codes 0..5 address row indices 0..5 and row codes 8..13 address row indices 6..11. A write lands in bit `col*12 + row_index` of `xpt_state_o`.
- R3: A write with row code 6, 7, 14 or 15 leaves all 96 bits unchanged.
- R4: Column codes 0..7 address columns 0..7 directly.
- R5: While `wr_strobe_i` is held high, the addressed bit follows `wr_data_i`. A change at the input shows at the output 3 clock cycles later (2 synchronizer stages plus the cell register).
- R6: The addressed bit keeps the data value present when the strobe falls. Later changes of data or address while the strobe is low have no effect.
- R7: A write changes only the addressed bit. All other bits keep their state.
- R8: While `clear_i` is high, all 96 bits read 0, whether or not the strobe is high. When clear and strobe fall together, no write takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_strobe_i | input | 1 | Write strobe, active high, level-sensitive |
| wr_data_i | input | 1 | Value for the addressed cell (1 = closed) |
| clear_i | input | 1 | Open all crosspoints, active high |
| row_code_i | input | 4 | Sparse row code |
| col_code_i | input | 3 | Column code |
| xpt_state_o | output | 96 | All control bits, index col*12+row |

## Verification
The bench makes single writes to the first and last live row codes of both halves and to every column. These writes separate a correct sparse mapping from a linear one, and show where each cell lands in the vector. It then makes writes with the four dead codes to a populated memory; such writes must leave the memory unchanged, which a decoder that aliases codes would fail to do. It toggles data under a held strobe and after the strobe falls, which tells a transparent capture apart from an edge capture. Finally it runs a seeded random sequence with clears, including clear during an active strobe, against a reference array.

// File: rtl/xpt_pkg.sv
// Package: shared helpers for the crosspoint control memory.
// Assumes the row code is split into one "half" bit (MSB) and a low field
// indexing rows inside that half.
package xpt_pkg;

    // Number of cells for a given matrix size.
    function automatic int cell_count(input int rows, input int cols);
        return rows * cols;
    endfunction

    // Bits needed to hold a row index.
    function automatic int idx_width(input int rows);
        return (rows <= 2) ? 1 : $clog2(rows);
    endfunction

endpackage

// File: rtl/xpt_sync_bus.sv
// Module: xpt_sync_bus
// Brings a bus of asynchronous host inputs into the clock domain with a
// chain of STAGES flops. All bits see the same delay so fields that belong
// together stay aligned. Assumes the host keeps fields stable for at least
// one clock around strobe edges.
module xpt_sync_bus #(
    parameter int WIDTH  = 10,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] pipe [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage: capture raw input.
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[0] <= '0;
                    else        pipe[0] <= din;
                end
            end else begin : g_next
                // Later stages: shift one step further.
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[s] <= '0;
                    else        pipe[s] <= pipe[s-1];
                end
            end
        end
    endgenerate

    assign dout = pipe[STAGES-1];

endmodule

// File: rtl/xpt_addr_decode.sv
// Module: xpt_addr_decode
// Maps the sparse row code and column code to one write enable per cell,
// gated by the strobe level. Row codes whose low field is at or above
// ROWS/2 select nothing. Assumes ROWS is even and ROWS/2 <= 2**(ROW_AW-1).
module xpt_addr_decode
    import xpt_pkg::*;
#(
    parameter int ROW_AW = 4,
    parameter int COL_AW = 3,
    parameter int ROWS   = 12,
    parameter int COLS   = 8,
    localparam int CELLS = ROWS * COLS,
    localparam int HALF  = ROWS / 2,
    localparam int LOW_W = ROW_AW - 1,
    localparam int IDX_W = idx_width(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ROW_AW-1:0] row_code,
    input  logic [COL_AW-1:0] col_code,
    input  logic              strobe,
    output logic [CELLS-1:0]  wr_en
);

    logic [LOW_W-1:0] row_lo;
    logic             row_hi;
    logic             row_ok;
    logic             col_ok;
    logic [IDX_W-1:0] row_idx;

    // Split the row code, check the live range and form the dense index.
    always_comb begin
        row_lo  = row_code[LOW_W-1:0];
        row_hi  = row_code[ROW_AW-1];
        row_ok  = ({1'b0, row_lo} < (LOW_W+1)'(HALF));
        row_idx = IDX_W'(row_lo) + (row_hi ? IDX_W'(HALF) : IDX_W'(0));
        col_ok  = ({1'b0, col_code} < (COL_AW+1)'(COLS));
    end

    genvar c, r;
    generate
        for (c = 0; c < COLS; c++) begin : g_col
            for (r = 0; r < ROWS; r++) begin : g_row
                // Cell enable: full address match ANDed with strobe.
                assign wr_en[c*ROWS + r] = strobe && row_ok && col_ok &&
                                           (row_idx == IDX_W'(r)) &&
                                           (col_code == COL_AW'(c));
            end
        end
    endgenerate

    // R2, R4: at most one cell is ever enabled.
    a_r2_one_cell: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en));

    // R3: dead row codes enable no cell.
    a_r3_dead_row: assert property (@(posedge clk) disable iff (!rst_n)
        (row_code[LOW_W-1:0] >= LOW_W'(HALF)) |-> (wr_en == '0));

    // R5: with the strobe low no cell is enabled.
    a_r5_strobe_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |-> (wr_en == '0));

endmodule

// File: rtl/xpt_cell_array.sv
// Module: xpt_cell_array
// One register per crosspoint. An enabled cell takes the data bit every
// cycle (transparent capture), so it holds the value present on the last
// enabled cycle. Clear overrides any write. Assumes wr_en is one-hot or zero.
module xpt_cell_array #(
    parameter int CELLS = 96
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             data,
    input  logic [CELLS-1:0] wr_en,
    output logic [CELLS-1:0] cells
);

    genvar i;
    generate
        for (i = 0; i < CELLS; i++) begin : g_cell
            // Cell storage: reset/clear to open, else follow data when enabled.
            always_ff @(posedge clk) begin
                if (!rst_n)        cells[i] <= 1'b0;
                else if (clear)    cells[i] <= 1'b0;
                else if (wr_en[i]) cells[i] <= data;
            end

            // R7: a cell without enable and without clear keeps its value.
            a_r7_keep: assert property (@(posedge clk) disable iff (!rst_n)
                (!clear && !wr_en[i]) |=> $stable(cells[i]));

            // R5: an enabled cell shows the data of the previous cycle.
            a_r5_follow: assert property (@(posedge clk) disable iff (!rst_n)
                (!clear && wr_en[i]) |=> (cells[i] == $past(data)));
        end
    endgenerate

    // R8: clear empties the whole array on the next cycle.
    a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cells == '0));

endmodule

// File: rtl/crosspoint_ctrl_mem.sv
// Module: crosspoint_ctrl_mem
// Control memory for a ROWS x COLS crosspoint matrix. Host inputs are
// synchronised as one bus, decoded to a per-cell enable and written into the
// cell array. Output bit col*ROWS + row_index. Assumes the host holds the
// address stable from before the strobe rises until after it falls.
module crosspoint_ctrl_mem
    import xpt_pkg::*;
#(
    parameter int ROW_AW      = 4,
    parameter int COL_AW      = 3,
    parameter int ROWS        = 12,
    parameter int COLS        = 8,
    parameter int SYNC_STAGES = 2,
    localparam int CELLS = ROWS * COLS,
    localparam int BUS_W = ROW_AW + COL_AW + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_strobe_i,
    input  logic              wr_data_i,
    input  logic              clear_i,
    input  logic [ROW_AW-1:0] row_code_i,
    input  logic [COL_AW-1:0] col_code_i,
    output logic [CELLS-1:0]  xpt_state_o
);

    logic [BUS_W-1:0]  raw_bus;
    logic [BUS_W-1:0]  sync_bus;
    logic              clear_s;
    logic              strobe_s;
    logic              data_s;
    logic [ROW_AW-1:0] row_s;
    logic [COL_AW-1:0] col_s;
    logic [CELLS-1:0]  wr_en;
    logic [CELLS-1:0]  cells;

    // Pack host inputs so every field sees the same synchronizer delay.
    assign raw_bus = {clear_i, wr_strobe_i, wr_data_i, row_code_i, col_code_i};

    xpt_sync_bus #(
        .WIDTH  (BUS_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_bus),
        .dout (sync_bus)
    );

    // Unpack the synchronised bus.
    assign {clear_s, strobe_s, data_s, row_s, col_s} = sync_bus;

    xpt_addr_decode #(
        .ROW_AW(ROW_AW),
        .COL_AW(COL_AW),
        .ROWS  (ROWS),
        .COLS  (COLS)
    ) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .row_code(row_s),
        .col_code(col_s),
        .strobe  (strobe_s),
        .wr_en   (wr_en)
    );

    xpt_cell_array #(
        .CELLS(CELLS)
    ) u_cells (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(clear_s),
        .data (data_s),
        .wr_en(wr_en),
        .cells(cells)
    );

    assign xpt_state_o = cells;

    // R1: reset leaves every crosspoint open.
    a_r1_reset_open: assert property (@(posedge clk)
        !rst_n |=> (xpt_state_o == '0));

    // R3: with a synchronised dead row code the output does not move.
    a_r3_dead_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_s && (row_s[ROW_AW-2:0] >= (ROW_AW-1)'(ROWS/2))) |=> $stable(xpt_state_o));

    // R6: with the synchronised strobe low and no clear the output holds.
    a_r6_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_s && !clear_s) |=> $stable(xpt_state_o));

endmodule

// File: tb/sim_crosspoint_ctrl_mem.sv
// Directed bench for crosspoint_ctrl_mem with a reference array.
module sim_crosspoint_ctrl_mem;

    localparam int ROWS = 12;
    localparam int COLS = 8;
    localparam int N    = ROWS * COLS;
    localparam int SETTLE = 6;   // > 3-cycle input-to-output latency

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_strobe_i = 1'b0;
    logic          wr_data_i = 1'b0;
    logic          clear_i = 1'b0;
    logic [3:0]    row_code_i = '0;
    logic [2:0]    col_code_i = '0;
    logic [N-1:0]  xpt_state_o;

    logic [N-1:0]  ref_mem;
    int            n_checks = 0;
    int            n_fail   = 0;
    bit            done     = 1'b0;

    always #5 clk = ~clk;   // 100 MHz

    crosspoint_ctrl_mem u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_strobe_i(wr_strobe_i),
        .wr_data_i  (wr_data_i),
        .clear_i    (clear_i),
        .row_code_i (row_code_i),
        .col_code_i (col_code_i),
        .xpt_state_o(xpt_state_o)
    );

    // Reference mapping from row code to row index; -1 for dead codes.
    function automatic int row_of(input int code);
        if (code <= 5)                  return code;
        if (code >= 8 && code <= 13)    return code - 2;
        return -1;
    endfunction

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_all(input string tag);
        n_checks++;
        if (xpt_state_o !== ref_mem) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, xpt_state_o, ref_mem);
        end
    endtask

    task automatic check_bit(input string tag, input int idx, input logic exp);
        n_checks++;
        if (xpt_state_o[idx] !== exp) begin
            n_fail++;
            $display("FAIL %s: bit %0d got %b expected %b", tag, idx, xpt_state_o[idx], exp);
        end
    endtask

    // Full write cycle: address set up, strobe pulse, address held, settle.
    task automatic do_write(input int row, input int col, input logic d);
        @(negedge clk);
        row_code_i = 4'(row);
        col_code_i = 3'(col);
        wr_data_i  = d;
        wait_cyc(1);
        wr_strobe_i = 1'b1;
        wait_cyc(2);
        wr_strobe_i = 1'b0;
        wait_cyc(1);
        wr_data_i = ~d;
        wait_cyc(SETTLE);
        if (row_of(row) >= 0) ref_mem[col*ROWS + row_of(row)] = d;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        wait_cyc(3);
        ref_mem = '0;
        check_all("R1 reset");
        rst_n = 1'b1;
        wait_cyc(2);
        check_all("R1 after release");
    endtask

    task automatic t_mapping;
        int rows_t[4] = '{0, 5, 8, 13};
        foreach (rows_t[k]) begin
            do_write(rows_t[k], k, 1'b1);
            check_all("R2 row mapping");
        end
        for (int c = 0; c < COLS; c++) begin
            do_write(3, c, 1'b1);
            check_all("R4 column select");
        end
    endtask

    task automatic t_dead_rows;
        int dead[4] = '{6, 7, 14, 15};
        foreach (dead[k]) begin
            do_write(dead[k], k * 2, 1'b1);
            check_all("R3 dead row code");
            do_write(dead[k], 3, 1'b0);
            check_all("R3 dead row code clearing");
        end
    endtask

    task automatic t_transparent;
        int idx = 7 * ROWS + 11;    // row code 13, column 7
        @(negedge clk);
        row_code_i = 4'd13;
        col_code_i = 3'd7;
        wr_data_i  = 1'b1;
        wait_cyc(1);
        wr_strobe_i = 1'b1;
        wait_cyc(3);
        check_bit("R5 latency 3 cycles", idx, 1'b1);
        wr_data_i = 1'b0;
        wait_cyc(3);
        check_bit("R5 follows data low", idx, 1'b0);
        wr_data_i = 1'b1;
        wait_cyc(3);
        check_bit("R5 follows data high", idx, 1'b1);
        wr_data_i = 1'b0;
        wait_cyc(1);
        wr_strobe_i = 1'b0;     // falls with data 0
        wait_cyc(1);
        wr_data_i = 1'b1;
        wait_cyc(SETTLE);
        ref_mem[idx] = 1'b0;
        check_all("R6 value at strobe fall");
        row_code_i = 4'd0;
        col_code_i = 3'd0;
        wait_cyc(SETTLE);
        check_all("R6 strobe low ignores inputs");
    endtask

    task automatic t_clear;
        do_write(1, 2, 1'b1);
        @(negedge clk);
        row_code_i = 4'd9;
        col_code_i = 3'd4;
        wr_data_i  = 1'b1;
        clear_i    = 1'b1;
        wr_strobe_i = 1'b1;
        wait_cyc(SETTLE);
        ref_mem = '0;
        check_all("R8 clear during strobe");
        clear_i     = 1'b0;
        wr_strobe_i = 1'b0;
        wait_cyc(SETTLE);
        check_all("R8 clear and strobe fall together");
    endtask

    task automatic t_random;
        int unsigned seed = 32'h5eed_1234;
        for (int n = 0; n < 60; n++) begin
            int r = $urandom(seed) % 16;
            int c = $urandom() % 8;
            logic d = 1'($urandom() % 2);
            seed = 0;
            if (($urandom() % 15) == 0) begin
                @(negedge clk);
                clear_i = 1'b1;
                wait_cyc(2);
                clear_i = 1'b0;
                wait_cyc(SETTLE);
                ref_mem = '0;
                check_all("R8 random clear");
            end else begin
                do_write(r, c, d);
                check_all("R7 random write, others kept");
            end
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        ref_mem = '0;
        t_reset();
        t_mapping();
        t_dead_rows();
        t_transparent();
        t_clear();
        t_random();
        t_reset();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule